// File: doc/BRIEF.md
# Chroma Subcarrier Quadrature Demodulator

This block takes a stream of signed, already bandpass-filtered chroma samples and turns it into one interleaved stream of colour-difference values. An internal phase accumulator runs at a per-standard frequency step and supplies two reference waves a quarter turn apart. A shared pair of multipliers then either demodulates the samples in quadrature (PAL, NTSC) or, for SECAM, uses the in-phase wave alone as a down-mixing local oscillator.

The accepted samples alternate between a U slot and a V slot. Each slot's rounded product is averaged with the previous product of the same slot, which gives a simple two-tap lowpass, and is emitted with a valid strobe and a slot flag. A signed phase-offset input rotates both references. It lets a hue control or an outside burst-lock loop steer the demodulation angle without touching the accumulator.

Top module: `chromaQuadDemod`

## Requirements
- R1: After reset, outValid is 0, outData is 0 and outSel is 0. The phase accumulator is at zero, the next accepted sample goes to the U slot, and both slot histories hold zero.
- R2: Every cycle with inValid=1 yields exactly one cycle with outValid=1 two clock edges later. A cycle with inValid=0 yields none, and outData holds its value while outValid is 0.
- R3: outSel marks the slot, with 0 for U and 1 for V. It alternates on every accepted sample, starting with U after reset, and idle cycles do not advance it.
- R4: The reference phase is the accumulator plus phaseOff placed in the top OFF_W bits of the phase word. The sine reference is read at that phase and the cosine reference a quarter turn later, both with amplitude 2^(DATA_W-1)-1. In PAL and NTSC, U-slot samples are multiplied by the sine reference and V-slot samples by the cosine reference.
- R5: stdSel selects the accumulator step. Code 0 uses PAL_INC, 1 uses NTSC_INC, 2 uses SECAM_INC, and 3 behaves as code 0. The accumulator advances by the step once after each accepted sample and never on idle cycles.
- R6: With stdSel=2 (SECAM), both slots carry the product with the cosine reference.
- R7: Each product is rounded as floor((sample*reference + 2^(DATA_W-2)) / 2^(DATA_W-1)). The result always lies in [-(2^(DATA_W-1)-1), 2^(DATA_W-1)-1].
- R8: outData is floor((current rounded product + previous rounded product of the same slot + 1) / 2).
- R9: phaseOff affects only the sample it accompanies. The accumulator is never changed by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Chroma sample present this cycle |
| inSample | input | DATA_W | Signed chroma sample |
| stdSel | input | 2 | Colour standard: 0 PAL, 1 NTSC, 2 SECAM, 3 as PAL |
| phaseOff | input | OFF_W | Signed reference rotation, full scale equals one turn |
| outValid | output | 1 | Output sample present |
| outSel | output | 1 | Slot of the output sample: 0 U, 1 V |
| outData | output | DATA_W | Signed filtered colour-difference value |

## Verification
Some properties are checked on every cycle: the two-edge valid latency, the strict U/V alternation of outSel, the hold of outData between valid samples, and the exclusion of the most negative code from outData. The values themselves cannot be seen by a property. These are the reference angle chosen per standard and offset, the SECAM switch to the in-phase wave, rounding, and averaging against the correct slot history. Only the bench scenarios show them. The bench sets quarter-turn step sizes so that every reference value is exact, and mixes gaps, standard changes, extreme samples and a reset in mid-stream.

// File: rtl/chromaDemodPkg.sv
package chromaDemodPkg;

  // Colour standard codes on stdSel; code 3 falls back to the PAL step.
  typedef enum logic [1:0] {
    STD_PAL   = 2'd0,
    STD_NTSC  = 2'd1,
    STD_SECAM = 2'd2,
    STD_ALT   = 2'd3
  } colorStd_e;

  // Strobes from the oscillator control to the mixing datapath.
  typedef struct packed {
    logic take;     // sample accepted this cycle
    logic slotV;    // sample belongs to the V slot
    logic mixOnly;  // down-mix with the in-phase wave only
  } demodCtl_t;

endpackage

// File: rtl/chromaDtoCtrl.sv
module chromaDtoCtrl
  import chromaDemodPkg::*;
#(
  parameter int          PHASE_W   = 24,
  parameter int          OFF_W     = 8,
  parameter int unsigned PAL_INC   = 5509888,
  parameter int unsigned NTSC_INC  = 4448530,
  parameter int unsigned SECAM_INC = 5326580
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [1:0]         stdSel,
  input  logic [OFF_W-1:0]   phaseOff,
  output demodCtl_t          ctl,
  output logic [PHASE_W-1:0] refPhase
);

  localparam int LOW_W = PHASE_W - OFF_W;

  colorStd_e          stdNow;
  logic [PHASE_W-1:0] phaseAcc;
  logic [PHASE_W-1:0] phaseStep;
  logic               slotV;

  assign stdNow = colorStd_e'(stdSel);

  always_comb begin
    case (stdNow)
      STD_NTSC:  phaseStep = PHASE_W'(NTSC_INC);
      STD_SECAM: phaseStep = PHASE_W'(SECAM_INC);
      default:   phaseStep = PHASE_W'(PAL_INC);
    endcase
  end

  // Offset rotates the references only; the accumulator never sees it.
  assign refPhase = phaseAcc + {phaseOff, {LOW_W{1'b0}}};

  assign ctl.take    = inValid;
  assign ctl.slotV   = slotV;
  assign ctl.mixOnly = (stdNow == STD_SECAM);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseAcc <= '0;
      slotV    <= 1'b0;
    end else if (inValid) begin
      phaseAcc <= phaseAcc + phaseStep;
      slotV    <= ~slotV;
    end
  end

endmodule

// File: rtl/chromaMixPath.sv
module chromaMixPath
  import chromaDemodPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PHASE_W = 24,
  parameter int LUT_W   = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  demodCtl_t          ctl,
  input  logic [PHASE_W-1:0] refPhase,
  input  logic [DATA_W-1:0]  inSample,
  output logic               outValid,
  output logic               outSel,
  output logic [DATA_W-1:0]  outData
);

  localparam int N_PTS     = 1 << LUT_W;
  localparam int PROD_W    = 2 * DATA_W;
  localparam int RND_SHIFT = DATA_W - 1;
  localparam int AMP       = (1 << (DATA_W - 1)) - 1;
  localparam logic [PHASE_W-1:0] QUARTER = {2'b01, {(PHASE_W-2){1'b0}}};
  localparam logic signed [PROD_W-1:0] HALF_LSB = PROD_W'(1) << (RND_SHIFT - 1);

  typedef logic [N_PTS:0][DATA_W-1:0] sinTab_t;

  // Odd power series, accurate far below one LSB over [0, pi/2].
  function automatic real sinSeries(input real x);
    real term;
    real acc;
    term = x;
    acc  = x;
    for (int k = 1; k < 8; k++) begin
      term = -term * x * x / real'((2 * k) * (2 * k + 1));
      acc  = acc + term;
    end
    return acc;
  endfunction

  // Quarter wave plus its end point, so a quarter turn reads full scale.
  function automatic sinTab_t buildTab();
    sinTab_t t;
    for (int i = 0; i <= N_PTS; i++) begin
      t[i] = DATA_W'(int'(real'(AMP) * sinSeries(1.5707963267948966 * real'(i) / real'(N_PTS))));
    end
    return t;
  endfunction

  localparam sinTab_t SIN_TAB = buildTab();

  function automatic logic signed [DATA_W-1:0] waveAt(input logic [PHASE_W-1:0] ph);
    logic [1:0]        quad;
    logic [LUT_W:0]    idx;
    logic [LUT_W:0]    pos;
    logic [DATA_W-1:0] mag;
    quad = ph[PHASE_W-1 -: 2];
    idx  = {1'b0, ph[PHASE_W-3 -: LUT_W]};
    pos  = quad[0] ? ((LUT_W+1)'(N_PTS) - idx) : idx;
    mag  = SIN_TAB[pos];
    return quad[1] ? -$signed(mag) : $signed(mag);
  endfunction

  logic signed [DATA_W-1:0] rndArm [2];

  // Arm 0: sine reference, arm 1: cosine reference (quarter turn ahead).
  for (genvar g = 0; g < 2; g++) begin : g_arm
    logic [PHASE_W-1:0]       armPhase;
    logic signed [DATA_W-1:0] armRef;
    logic signed [PROD_W-1:0] armProd;
    logic signed [PROD_W-1:0] armBiased;

    assign armPhase  = refPhase + ((g == 0) ? '0 : QUARTER);
    assign armRef    = waveAt(armPhase);
    assign armProd   = PROD_W'($signed(inSample)) * PROD_W'(armRef);
    assign armBiased = armProd + HALF_LSB;
    assign rndArm[g] = DATA_W'(armBiased >>> RND_SHIFT);
  end

  logic signed [DATA_W-1:0] picked;
  assign picked = (ctl.mixOnly || ctl.slotV) ? rndArm[1] : rndArm[0];

  // Stage 1: rounded product of the active slot.
  logic              p1Valid;
  logic              p1Sel;
  logic [DATA_W-1:0] p1Val;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      p1Valid <= 1'b0;
      p1Sel   <= 1'b0;
      p1Val   <= '0;
    end else begin
      p1Valid <= ctl.take;
      if (ctl.take) begin
        p1Sel <= ctl.slotV;
        p1Val <= picked;
      end
    end
  end

  // Stage 2: two-tap average against the same slot's previous product.
  logic [DATA_W-1:0] slotHist [2];
  logic [DATA_W:0]   avgSum;
  logic [DATA_W-1:0] avgVal;

  assign avgSum = (DATA_W+1)'($signed(p1Val)) + (DATA_W+1)'($signed(slotHist[p1Sel])) + (DATA_W+1)'(1);
  assign avgVal = DATA_W'(avgSum >> 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      outSel      <= 1'b0;
      outData     <= '0;
      slotHist[0] <= '0;
      slotHist[1] <= '0;
    end else begin
      outValid <= p1Valid;
      if (p1Valid) begin
        outSel          <= p1Sel;
        outData         <= avgVal;
        slotHist[p1Sel] <= p1Val;
      end
    end
  end

endmodule

// File: rtl/chromaQuadDemod.sv
module chromaQuadDemod
  import chromaDemodPkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter int          PHASE_W   = 24,
  parameter int          OFF_W     = 8,
  parameter int          LUT_W     = 6,
  parameter int unsigned PAL_INC   = 5509888,
  parameter int unsigned NTSC_INC  = 4448530,
  parameter int unsigned SECAM_INC = 5326580
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inSample,
  input  logic [1:0]        stdSel,
  input  logic [OFF_W-1:0]  phaseOff,
  output logic              outValid,
  output logic              outSel,
  output logic [DATA_W-1:0] outData
);

  demodCtl_t          ctl;
  logic [PHASE_W-1:0] refPhase;

  chromaDtoCtrl #(
    .PHASE_W  (PHASE_W),
    .OFF_W    (OFF_W),
    .PAL_INC  (PAL_INC),
    .NTSC_INC (NTSC_INC),
    .SECAM_INC(SECAM_INC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .stdSel  (stdSel),
    .phaseOff(phaseOff),
    .ctl     (ctl),
    .refPhase(refPhase)
  );

  chromaMixPath #(
    .DATA_W (DATA_W),
    .PHASE_W(PHASE_W),
    .LUT_W  (LUT_W)
  ) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .refPhase(refPhase),
    .inSample(inSample),
    .outValid(outValid),
    .outSel  (outSel),
    .outData (outData)
  );

endmodule

// File: rtl/chromaDemodChecker.sv
module chromaDemodChecker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              outValid,
  input logic              outSel,
  input logic [DATA_W-1:0] outData
);

  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic [1:0] edgesSinceRst;
  logic       lastSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgesSinceRst <= 2'd0;
      lastSel       <= 1'b1;
    end else begin
      if (edgesSinceRst != 2'd2) edgesSinceRst <= edgesSinceRst + 2'd1;
      if (outValid) lastSel <= outSel;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (edgesSinceRst == 2'd2) |-> (outValid == $past(inValid, 2))); // R2

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (edgesSinceRst != 2'd0 && !outValid) |-> $stable(outData)); // R2

  AST_SLOT_ALTERNATES: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outSel != lastSel)); // R3

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (edgesSinceRst != 2'd0 && !outValid) |-> $stable(outSel)); // R3

  AST_NO_MOST_NEG: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outData != MOST_NEG)); // R7

endmodule

bind chromaQuadDemod chromaDemodChecker #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .outValid(outValid),
  .outSel  (outSel),
  .outData (outData)
);

// File: tb/chromaQuadDemod_tb.sv
`timescale 1ns/1ps
module chromaQuadDemod_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] inSample = '0;
  logic [1:0] stdSel = '0;
  logic [7:0] phaseOff = '0;
  logic       outValid;
  logic       outSel;
  logic [7:0] outData;

  always #2 clk = ~clk;

  // Quarter-turn steps make every reference value exact: PAL 1, NTSC 2, SECAM 3 quarters.
  chromaQuadDemod #(
    .PAL_INC  (32'h0040_0000),
    .NTSC_INC (32'h0080_0000),
    .SECAM_INC(32'h00C0_0000)
  ) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSample(inSample),
    .stdSel(stdSel), .phaseOff(phaseOff),
    .outValid(outValid), .outSel(outSel), .outData(outData)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model state
  int accQ = 0, slotV = 0, prevU = 0, prevV = 0;

  function automatic int rnd(input int p);
    return (p + 64) >>> 7;
  endfunction

  function automatic int waveQ(input int q);
    case (q & 3)
      1: return 127;
      3: return -127;
      default: return 0;
    endcase
  endfunction

  task automatic modelReset();
    accQ = 0; slotV = 0; prevU = 0; prevV = 0;
  endtask

  task automatic modelStep(input int std, input int off, input int s, output int sel, output int data);
    int q, sinT, cosT, cur, prev;
    q    = ((accQ * 64 + off) & 255) >> 6;
    sinT = waveQ(q);
    cosT = waveQ(q + 1);
    cur  = (std == 2 || slotV == 1) ? rnd(s * cosT) : rnd(s * sinT);
    prev = slotV ? prevV : prevU;
    data = (cur + prev + 1) >>> 1;
    sel  = slotV;
    if (slotV) prevV = cur; else prevU = cur;
    slotV = 1 - slotV;
    accQ  = (accQ + ((std == 1) ? 2 : (std == 2) ? 3 : 1)) % 4;
  endtask

  // {valid, std, offset, sample, requirement}
  localparam int NV = 20;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 2'd0, 8'h00, 8'd100, 4'd4},  // R4 PAL U at 0 deg
    {1'b1, 2'd0, 8'h00, 8'd100, 4'd4},  // R4 PAL V at 90 deg
    {1'b1, 2'd0, 8'h00, 8'h80,  4'd7},  // R7 most negative sample
    {1'b1, 2'd0, 8'h00, 8'h7F,  4'd7},  // R7 most positive sample
    {1'b0, 2'd0, 8'h00, 8'd55,  4'd2},  // R2 idle
    {1'b1, 2'd0, 8'h40, 8'd50,  4'd9},  // R9 offset +90
    {1'b0, 2'd1, 8'h00, 8'd11,  4'd2},  // R2 idle
    {1'b0, 2'd2, 8'h40, 8'd22,  4'd2},  // R2 idle
    {1'b1, 2'd1, 8'h00, 8'd90,  4'd5},  // R5 NTSC half-turn step
    {1'b1, 2'd1, 8'h00, 8'hA6,  4'd5},  // R5
    {1'b1, 2'd1, 8'h00, 8'd60,  4'd8},  // R8
    {1'b1, 2'd2, 8'h00, 8'd70,  4'd6},  // R6 SECAM cosine in U slot
    {1'b1, 2'd2, 8'h00, 8'd70,  4'd6},  // R6
    {1'b1, 2'd2, 8'h40, 8'hD8,  4'd6},  // R6 with offset
    {1'b1, 2'd3, 8'h00, 8'd33,  4'd5},  // R5 code 3 acts as PAL
    {1'b1, 2'd3, 8'h00, 8'hB3,  4'd5},  // R5
    {1'b1, 2'd0, 8'h80, 8'd120, 4'd9},  // R9 offset 180
    {1'b1, 2'd0, 8'hC0, 8'd120, 4'd9},  // R9 offset -90
    {1'b1, 2'd0, 8'h00, 8'd0,   4'd8},  // R8 decay toward zero
    {1'b1, 2'd0, 8'h00, 8'hFF,  4'd7}   // R7 rounding of -1
  };

  int expV [NV];
  int expS [NV];
  int expD [NV];
  int expR [NV];

  task automatic checkSlot(input int k);
    if (expV[k] != 0) begin
      chk(outValid == 1'b1, "R2", int'(outValid), 1);
      chk(int'(outSel) == expS[k], "R3", int'(outSel), expS[k]);
      chk(int'($signed(outData)) == expD[k], $sformatf("R%0d", expR[k]), int'($signed(outData)), expD[k]);
    end else begin
      chk(outValid == 1'b0, "R2", int'(outValid), 0);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(outValid == 1'b0, "R1", int'(outValid), 0);
    chk(outData == 8'd0, "R1", int'(outData), 0);
    chk(outSel == 1'b0, "R1", int'(outSel), 0);

    modelReset();
    for (int k = 0; k < NV + 2; k++) begin
      @(negedge clk);
      if (k >= 2) checkSlot(k - 2);
      if (k < NV) begin
        int sel, data;
        inValid  = VEC[k][22];
        stdSel   = VEC[k][21:20];
        phaseOff = VEC[k][19:12];
        inSample = VEC[k][11:4];
        expV[k]  = int'(VEC[k][22]);
        expR[k]  = int'(VEC[k][3:0]);
        sel = 0; data = 0;
        if (VEC[k][22]) modelStep(int'(VEC[k][21:20]), int'($signed(VEC[k][19:12])),
                                  int'($signed(VEC[k][11:4])), sel, data);
        expS[k] = sel;
        expD[k] = data;
      end else begin
        inValid = 1'b0;
      end
    end

    // Reset in mid-stream: the pending sample is dropped and all state clears (R1).
    inValid = 1'b1; stdSel = 2'd0; phaseOff = 8'h00; inSample = 8'd77;
    @(negedge clk);
    rstN = 1'b0; inValid = 1'b0;
    repeat (2) @(negedge clk);
    chk(outValid == 1'b0, "R1", int'(outValid), 0);
    chk(outData == 8'd0, "R1", int'(outData), 0);
    rstN = 1'b1;
    // First sample after reset: U slot, phase 0 + 90 deg offset, history zero (R1, R4).
    inValid = 1'b1; stdSel = 2'd0; phaseOff = 8'h40; inSample = 8'd100;
    @(negedge clk);
    // Accumulator at 90 deg; offset -90 gives cosine of 0 deg (R9).
    phaseOff = 8'hC0; inSample = 8'd100;
    @(negedge clk);
    chk(outValid == 1'b1, "R2", int'(outValid), 1);
    chk(outSel == 1'b0, "R1", int'(outSel), 0);
    chk(int'($signed(outData)) == 50, "R1", int'($signed(outData)), 50);
    // SECAM at accumulator 180 deg: cosine -127 in the U slot (R6).
    stdSel = 2'd2; phaseOff = 8'h00; inSample = 8'h9C;
    @(negedge clk);
    chk(outSel == 1'b1, "R3", int'(outSel), 1);
    chk(int'($signed(outData)) == 50, "R9", int'($signed(outData)), 50);
    inValid = 1'b0;
    @(negedge clk);
    chk(outSel == 1'b0, "R6", int'(outSel), 0);
    chk(int'($signed(outData)) == 99, "R6", int'($signed(outData)), 99);
    @(negedge clk);
    chk(outValid == 1'b0, "R2", int'(outValid), 0);

    finishRun();
  end

endmodule